// File: doc/BRIEF.md
# Dual-Role Type-C Attach and Orientation Controller

This block runs the configuration-channel terminations of a USB Type-C port that can act as either power source or power sink. Analog comparators outside the block report the level seen on each CC pin. The block turns the pull-up (Rp) and pull-down (Rd) terminations on and off for each pin. While nothing is attached it switches back and forth between a source phase and a sink phase. Once a partner has been stable for a debounce time, it settles on a role.

As source, the block finds which pin carries the CC wire, takes Rp off the other pin and enables Vbus. If the other pin shows an Ra load from a powered cable, it drives Vconn onto that pin. Both pins at Ra level mean an audio adapter, and in that case Vconn is never enabled. As sink, the block attaches when a pull-up level and Vbus are both present.

Without local power the port shows Rd on both pins, so a powered partner can still charge it. An input selects a bias toward the source role, so that the port becomes source when it meets another dual-role port.

Top module: `typec_drp_attach`

## Requirements
- R1: During reset and whenever local power is absent in an unattached state, rdEn is 2'b11, while rpEn, vconnEn and vbusEn are zero. Bit 0 of every per-pin vector belongs to CC1 and bit 1 to CC2.
- R2: With power and no partner, the port spends SRC_CYC cycles in the source phase (rpEn=2'b11, rdEn=0) and SNK_CYC cycles in the sink phase (rpEn=0, rdEn=2'b11), and keeps alternating.
- R3: A CC level code (0 open, 1 Rd, 2 Ra, 3 Rp) has no effect until it has been stable for DEB_CYC cycles. A shorter pulse leaves the outputs unchanged.
- R4: In a source phase, Rd on one pin with the other pin open or at Ra gives attached=1 and roleSrc=1. orientFlip is 0 for Rd on CC1 and 1 for Rd on CC2. vbusEn=1, and Rp stays only on the CC pin.
- R5: When the non-CC pin shows Ra at source attach, cableFlag=1 and vconnEn is set for that pin only. With the pin open, vconnEn stays 0. vconnEn never overlaps rpEn.
- R6: Ra on both pins in a source phase gives audioFlag=1, with attached=0, vbusEn=0, vconnEn=0 and Rp kept on both pins.
- R7: Rd on both pins does not attach. The port keeps toggling.
- R8: In a sink phase, Rp on a pin together with vbusPresent gives attached=1, roleSrc=0, orientFlip set by the pin, vbusEn=0 and rdEn=2'b11.
- R9: With trySrcEn=1, a partner that offers Rp during the sink phase makes the port present Rp for TRY_CYC cycles. A dual-role partner then ends as sink and this port as source. With trySrcEn=0 the same encounter ends with this port as sink.
- R10: As source, a CC pin that has been open for DEB_CYC cycles removes Vbus and Vconn and returns the port to the source phase. A shorter opening keeps the attachment.
- R11: As sink, loss of vbusPresent ends the attachment.
- R12: Loss of local power removes Rp by the next cycle. An unpowered port still attaches as sink to a source partner, and it stays attached when power returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| localPwrOk | input | 1 | Local supply able to source power |
| trySrcEn | input | 1 | Bias toward the source role |
| vbusPresent | input | 1 | Vbus detected on the connector |
| cc1Lvl | input | 2 | CC1 comparator class: 0 open, 1 Rd, 2 Ra, 3 Rp |
| cc2Lvl | input | 2 | CC2 comparator class, same coding |
| rpEn | output | 2 | Pull-up enable per pin |
| rdEn | output | 2 | Pull-down enable per pin |
| vconnEn | output | 2 | Vconn supply enable per pin |
| vbusEn | output | 1 | Enable 5 V on Vbus |
| orientFlip | output | 1 | 1 when CC2 carries the CC wire |
| attached | output | 1 | Attached as source or sink |
| roleSrc | output | 1 | Attached role is source |
| cableFlag | output | 1 | Powered cable detected |
| audioFlag | output | 1 | Audio adapter detected |

## Verification
The bench builds the block with DEB_CYC=8, SRC_CYC=40, SNK_CYC=40 and TRY_CYC=30, so a full toggle period and every debounce window fit inside a few hundred cycles. These values let the bench measure exact phase lengths, apply pulses just shorter than the debounce time, and place a dual-role partner at the start of a sink phase to show the effect of the bias. Many random attach and detach episodes then run within the cycle budget.

// File: rtl/tcdrp_pkg.sv
`timescale 1ns/1ps
package tcdrp_pkg;
  typedef enum logic [1:0] {LV_OPEN = 2'd0, LV_RD = 2'd1, LV_RA = 2'd2, LV_RP = 2'd3} ccLvl_e;
  typedef enum logic [1:0] {TM_SRC, TM_SNK, TM_TRY} tmSel_e;
  typedef enum logic [2:0] {
    ST_UNPWR, ST_TOG_SRC, ST_TOG_SNK, ST_TRY_SRC,
    ST_WAIT_SNK, ST_ATT_SRC, ST_ATT_SNK, ST_AUDIO
  } attSt_e;
  typedef struct packed {
    logic   tmrLoad;
    tmSel_e tmrSel;
    logic   dbClear;
  } ctlStrobe_t;
endpackage

// File: rtl/tcdrp_datapath.sv
`timescale 1ns/1ps
module tcdrp_datapath
  import tcdrp_pkg::*;
#(
  parameter int DEB_CYC = 20000,
  parameter int SRC_CYC = 50000,
  parameter int SNK_CYC = 50000,
  parameter int TRY_CYC = 30000
) (
  input  logic       clk,
  input  logic       rstN,
  input  ccLvl_e     rawLvl [2],
  input  ctlStrobe_t strb,
  output ccLvl_e     dbLvl [2],
  output logic       tmrDone
);
  localparam int DW = $clog2(DEB_CYC + 1);
  localparam int MAXA = (SRC_CYC > SNK_CYC) ? SRC_CYC : SNK_CYC;
  localparam int MAXT = (MAXA > TRY_CYC) ? MAXA : TRY_CYC;
  localparam int TW = $clog2(MAXT + 1);
  localparam logic [DW-1:0] DEB_LAST = DW'(DEB_CYC - 1);

  // per-pin debounce filters
  for (genvar g = 0; g < 2; g++) begin : gPin
    ccLvl_e cand;
    logic [DW-1:0] stCnt;
    always_ff @(posedge clk) begin
      if (!rstN || strb.dbClear) begin
        cand     <= LV_OPEN;
        stCnt    <= '0;
        dbLvl[g] <= LV_OPEN;
      end else if (rawLvl[g] != cand) begin
        cand  <= rawLvl[g];
        stCnt <= '0;
      end else if (stCnt != DEB_LAST) begin
        stCnt <= stCnt + 1'b1;
      end else begin
        dbLvl[g] <= cand;
      end
    end
  end

  // phase timer, counts down to zero
  logic [TW-1:0] tmr;
  logic [TW-1:0] loadVal;
  always_comb begin
    case (strb.tmrSel)
      TM_SRC:  loadVal = TW'(SRC_CYC - 1);
      TM_SNK:  loadVal = TW'(SNK_CYC - 1);
      default: loadVal = TW'(TRY_CYC - 1);
    endcase
  end
  always_ff @(posedge clk) begin
    if (!rstN)             tmr <= '0;
    else if (strb.tmrLoad) tmr <= loadVal;
    else if (tmr != '0)    tmr <= tmr - 1'b1;
  end
  assign tmrDone = (tmr == '0);
endmodule

// File: rtl/tcdrp_control.sv
`timescale 1ns/1ps
module tcdrp_control
  import tcdrp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       localPwrOk,
  input  logic       trySrcEn,
  input  logic       vbusPresent,
  input  ccLvl_e     dbLvl [2],
  input  logic       tmrDone,
  output ctlStrobe_t strb,
  output logic [1:0] rpEn,
  output logic [1:0] rdEn,
  output logic [1:0] vconnEn,
  output logic       vbusEn,
  output logic       orientFlip,
  output logic       attached,
  output logic       roleSrc,
  output logic       cableFlag,
  output logic       audioFlag
);
  attSt_e st, nxt;
  logic flipQ, cableQ, nFlip, nCable;
  ccLvl_e d0, d1, ccPin;
  logic srcHit, bothRa, rpSeen, powered;

  assign d0 = dbLvl[0];
  assign d1 = dbLvl[1];
  assign srcHit = (d0 == LV_RD && (d1 == LV_OPEN || d1 == LV_RA)) ||
                  (d1 == LV_RD && (d0 == LV_OPEN || d0 == LV_RA));
  assign bothRa = (d0 == LV_RA) && (d1 == LV_RA);
  assign rpSeen = (d0 == LV_RP) || (d1 == LV_RP);
  assign ccPin  = flipQ ? d1 : d0;
  assign powered = (st == ST_TOG_SRC) || (st == ST_TOG_SNK) || (st == ST_TRY_SRC) ||
                   (st == ST_WAIT_SNK) || (st == ST_ATT_SRC) || (st == ST_AUDIO);

  always_comb begin
    nxt = st;
    strb = '0;
    nFlip = flipQ;
    nCable = cableQ;
    if (!localPwrOk && powered) begin
      nxt = ST_UNPWR;
      strb.dbClear = 1'b1;
    end else begin
      case (st)
        ST_UNPWR: begin
          if (vbusPresent && rpSeen) begin
            nxt = ST_ATT_SNK; nFlip = (d1 == LV_RP) && (d0 != LV_RP); nCable = 1'b0;
          end else if (localPwrOk) begin
            nxt = ST_TOG_SRC; strb.tmrLoad = 1'b1; strb.tmrSel = TM_SRC; strb.dbClear = 1'b1;
          end
        end
        ST_TOG_SRC, ST_TRY_SRC: begin
          if (bothRa) nxt = ST_AUDIO;
          else if (srcHit) begin
            nxt = ST_ATT_SRC; nFlip = (d1 == LV_RD); nCable = (d0 == LV_RA) || (d1 == LV_RA);
          end else if (tmrDone) begin
            nxt = (st == ST_TOG_SRC) ? ST_TOG_SNK : ST_WAIT_SNK;
            strb.tmrLoad = 1'b1; strb.tmrSel = TM_SNK; strb.dbClear = 1'b1;
          end
        end
        ST_TOG_SNK, ST_WAIT_SNK: begin
          if (rpSeen && trySrcEn && st == ST_TOG_SNK) begin
            nxt = ST_TRY_SRC; strb.tmrLoad = 1'b1; strb.tmrSel = TM_TRY; strb.dbClear = 1'b1;
          end else if (rpSeen && vbusPresent) begin
            nxt = ST_ATT_SNK; nFlip = (d1 == LV_RP) && (d0 != LV_RP); nCable = 1'b0;
          end else if (tmrDone) begin
            nxt = ST_TOG_SRC; strb.tmrLoad = 1'b1; strb.tmrSel = TM_SRC; strb.dbClear = 1'b1;
          end
        end
        ST_ATT_SRC: begin
          if (ccPin == LV_OPEN) begin
            nxt = ST_TOG_SRC; strb.tmrLoad = 1'b1; strb.tmrSel = TM_SRC; strb.dbClear = 1'b1;
          end
        end
        ST_ATT_SNK: begin
          if (!vbusPresent || ccPin == LV_OPEN) begin
            strb.dbClear = 1'b1;
            if (localPwrOk) begin
              nxt = ST_TOG_SRC; strb.tmrLoad = 1'b1; strb.tmrSel = TM_SRC;
            end else nxt = ST_UNPWR;
          end
        end
        ST_AUDIO: begin
          if (!bothRa) begin
            nxt = ST_TOG_SRC; strb.tmrLoad = 1'b1; strb.tmrSel = TM_SRC; strb.dbClear = 1'b1;
          end
        end
        default: nxt = ST_UNPWR;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st <= ST_UNPWR; flipQ <= 1'b0; cableQ <= 1'b0;
    end else begin
      st <= nxt; flipQ <= nFlip; cableQ <= nCable;
    end
  end

  // Moore output decode
  always_comb begin
    rpEn = 2'b00; rdEn = 2'b00; vconnEn = 2'b00; vbusEn = 1'b0;
    case (st)
      ST_TOG_SRC, ST_TRY_SRC, ST_AUDIO: rpEn = 2'b11;
      ST_ATT_SRC: begin
        rpEn    = flipQ ? 2'b10 : 2'b01;
        vconnEn = cableQ ? (flipQ ? 2'b01 : 2'b10) : 2'b00;
        vbusEn  = 1'b1;
      end
      default: rdEn = 2'b11;
    endcase
  end
  assign attached   = (st == ST_ATT_SRC) || (st == ST_ATT_SNK);
  assign roleSrc    = (st == ST_ATT_SRC);
  assign orientFlip = attached & flipQ;
  assign cableFlag  = (st == ST_ATT_SRC) & cableQ;
  assign audioFlag  = (st == ST_AUDIO);
endmodule

// File: rtl/typec_drp_attach.sv
`timescale 1ns/1ps
module typec_drp_attach
  import tcdrp_pkg::*;
#(
  parameter int DEB_CYC = 20000,
  parameter int SRC_CYC = 50000,
  parameter int SNK_CYC = 50000,
  parameter int TRY_CYC = 30000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       localPwrOk,
  input  logic       trySrcEn,
  input  logic       vbusPresent,
  input  logic [1:0] cc1Lvl,
  input  logic [1:0] cc2Lvl,
  output logic [1:0] rpEn,
  output logic [1:0] rdEn,
  output logic [1:0] vconnEn,
  output logic       vbusEn,
  output logic       orientFlip,
  output logic       attached,
  output logic       roleSrc,
  output logic       cableFlag,
  output logic       audioFlag
);
  ccLvl_e rawLvl [2];
  ccLvl_e dbLvl [2];
  ctlStrobe_t strb;
  logic tmrDone;

  assign rawLvl[0] = ccLvl_e'(cc1Lvl);
  assign rawLvl[1] = ccLvl_e'(cc2Lvl);

  tcdrp_datapath #(.DEB_CYC(DEB_CYC), .SRC_CYC(SRC_CYC), .SNK_CYC(SNK_CYC), .TRY_CYC(TRY_CYC))
    u_dp (.clk(clk), .rstN(rstN), .rawLvl(rawLvl), .strb(strb), .dbLvl(dbLvl), .tmrDone(tmrDone));

  tcdrp_control u_ctl (
    .clk(clk), .rstN(rstN), .localPwrOk(localPwrOk), .trySrcEn(trySrcEn),
    .vbusPresent(vbusPresent), .dbLvl(dbLvl), .tmrDone(tmrDone), .strb(strb),
    .rpEn(rpEn), .rdEn(rdEn), .vconnEn(vconnEn), .vbusEn(vbusEn),
    .orientFlip(orientFlip), .attached(attached), .roleSrc(roleSrc),
    .cableFlag(cableFlag), .audioFlag(audioFlag));
endmodule

// File: rtl/typec_drp_attach_chk.sv
`timescale 1ns/1ps
module typec_drp_attach_chk (
  input logic       clk,
  input logic       rstN,
  input logic       localPwrOk,
  input logic [1:0] rpEn,
  input logic [1:0] rdEn,
  input logic [1:0] vconnEn,
  input logic       vbusEn,
  input logic       attached,
  input logic       roleSrc,
  input logic       cableFlag,
  input logic       audioFlag
);
  assert_term_excl_R1: assert property (@(posedge clk) disable iff (!rstN)
    (rpEn & rdEn) == 2'b00);
  assert_vbus_src_R4: assert property (@(posedge clk) disable iff (!rstN)
    vbusEn |-> (attached && roleSrc));
  assert_vconn_pin_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(vconnEn) && ((vconnEn & rpEn) == 2'b00));
  assert_vconn_cable_R5: assert property (@(posedge clk) disable iff (!rstN)
    (vconnEn != 2'b00) |-> (cableFlag && vbusEn));
  assert_audio_safe_R6: assert property (@(posedge clk) disable iff (!rstN)
    audioFlag |-> (vconnEn == 2'b00 && !vbusEn && !attached));
  assert_pwr_loss_R12: assert property (@(posedge clk) disable iff (!rstN)
    !localPwrOk |=> (rpEn == 2'b00));
endmodule

bind typec_drp_attach typec_drp_attach_chk u_chk (
  .clk(clk), .rstN(rstN), .localPwrOk(localPwrOk), .rpEn(rpEn), .rdEn(rdEn),
  .vconnEn(vconnEn), .vbusEn(vbusEn), .attached(attached), .roleSrc(roleSrc),
  .cableFlag(cableFlag), .audioFlag(audioFlag));

// File: tb/typec_drp_attach_tb.sv
`timescale 1ns/1ps
module typec_drp_attach_tb;
  import tcdrp_pkg::*;
  localparam int DEB = 8, SRCC = 40, SNKC = 40, TRYC = 30;
  localparam int P_NONE = 0, P_SNK = 1, P_SRC = 2, P_DRP = 3, P_AUD = 4, P_DBG = 5;

  logic clk = 1'b0;
  logic rstN, pwr, trySrc, vbus;
  logic [1:0] cc1, cc2;
  logic [1:0] rpEn, rdEn, vconnEn;
  logic vbusEn, orientFlip, attached, roleSrc, cableFlag, audioFlag;
  int ptype = P_NONE;
  logic pflip = 1'b0, pcable = 1'b0;
  int nChk = 0, nFail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  typec_drp_attach #(.DEB_CYC(DEB), .SRC_CYC(SRCC), .SNK_CYC(SNKC), .TRY_CYC(TRYC)) u_dut (
    .clk(clk), .rstN(rstN), .localPwrOk(pwr), .trySrcEn(trySrc), .vbusPresent(vbus),
    .cc1Lvl(cc1), .cc2Lvl(cc2), .rpEn(rpEn), .rdEn(rdEn), .vconnEn(vconnEn),
    .vbusEn(vbusEn), .orientFlip(orientFlip), .attached(attached), .roleSrc(roleSrc),
    .cableFlag(cableFlag), .audioFlag(audioFlag));

  function automatic logic [1:0] pinLvl(input int pin);
    logic isCc = (pin == int'(pflip));
    case (ptype)
      P_SNK: return isCc ? (rpEn[pin] ? 2'd1 : 2'd0) : (pcable ? 2'd2 : 2'd0);
      P_SRC: return isCc ? (rdEn[pin] ? 2'd3 : 2'd0) : 2'd0;
      P_DRP: return isCc ? (rpEn[pin] ? 2'd1 : (rdEn[pin] ? 2'd3 : 2'd0)) : 2'd0;
      P_AUD: return 2'd2;
      P_DBG: return rpEn[pin] ? 2'd1 : 2'd0;
      default: return 2'd0;
    endcase
  endfunction

  // partner model, updated away from the active edge
  always @(negedge clk) begin
    cc1 <= pinLvl(0);
    cc2 <= pinLvl(1);
    vbus <= (ptype == P_SRC || ptype == P_DRP) && rdEn[pflip] && !rpEn[pflip];
  end

  typedef struct packed {
    logic att, src, flip, vb, cab, aud;
    logic [1:0] vc, rp, rd;
  } exp_t;

  function automatic exp_t expect_of(input int t, input logic f, input logic c, input logic bias);
    exp_t e = '0;
    if (t == P_SNK || (t == P_DRP && bias)) begin
      e.att = 1; e.src = 1; e.flip = f; e.vb = 1; e.rp = f ? 2'b10 : 2'b01;
      e.cab = (t == P_SNK) && c;
      e.vc = e.cab ? (f ? 2'b01 : 2'b10) : 2'b00;
    end else if (t == P_SRC || t == P_DRP) begin
      e.att = 1; e.flip = f; e.rd = 2'b11;
    end else if (t == P_AUD) begin
      e.aud = 1; e.rp = 2'b11;
    end
    return e;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chkAll(input string tag, input exp_t e);
    exp_t a;
    a = '{att: attached, src: roleSrc, flip: orientFlip, vb: vbusEn, cab: cableFlag,
          aud: audioFlag, vc: vconnEn, rp: rpEn, rd: rdEn};
    chk(tag, int'(a), int'(e));
  endtask

  task automatic settle();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (attached || audioFlag) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic srcPhaseStart();
    while (rpEn == 2'b11) @(negedge clk);
    while (rpEn != 2'b11) @(negedge clk);
  endtask

  task automatic snkPhaseStart();
    while (rdEn == 2'b11) @(negedge clk);
    while (rdEn != 2'b11) @(negedge clk);
  endtask

  task automatic detachWait();
    ptype = P_NONE;
    repeat (40) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end

  initial begin
    int n;
    exp_t e;
    void'($urandom(32'h5EED_C0DE));
    rstN = 0; pwr = 1; trySrc = 0;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 rdEn", rdEn, 2'b11);
    chk("R1 rp/vconn/vbus", {rpEn, vconnEn, vbusEn}, 0);
    rstN = 1;

    // R2 phase lengths
    while (rpEn != 2'b11) @(negedge clk);
    n = 0;
    do begin @(negedge clk); n++; end while (rdEn != 2'b11);
    chk("R2 source phase", n, SRCC);
    chk("R2 sink terms", {rpEn, rdEn}, 4'b0011);
    n = 0;
    do begin @(negedge clk); n++; end while (rpEn != 2'b11);
    chk("R2 sink phase", n, SNKC);

    // R3 short pulse ignored
    ptype = P_SNK; pflip = 0; pcable = 0;
    repeat (DEB - 3) @(negedge clk);
    ptype = P_NONE;
    repeat (20) @(negedge clk);
    chk("R3 glitch no attach", {attached, vbusEn}, 0);

    // R4/R5 directed source attach, CC2, with cable
    srcPhaseStart();
    ptype = P_SNK; pflip = 1; pcable = 1;
    settle();
    chkAll("R4 R5 src attach cc2 cable", expect_of(P_SNK, 1, 1, 0));
    // R10 short open kept, then detach
    ptype = P_NONE;
    repeat (DEB - 3) @(negedge clk);
    chk("R10 short open keeps vbus", vbusEn, 1);
    ptype = P_SNK;
    repeat (20) @(negedge clk);
    chk("R10 still attached", attached, 1);
    ptype = P_NONE;
    repeat (DEB + 6) @(negedge clk);
    chk("R10 detach", {vbusEn, vconnEn, attached, rpEn}, 5'b00011);

    // R4 CC1 no cable
    srcPhaseStart();
    ptype = P_SNK; pflip = 0; pcable = 0;
    settle();
    chkAll("R4 src attach cc1", expect_of(P_SNK, 0, 0, 0));
    detachWait();

    // R6 audio
    ptype = P_AUD;
    settle();
    chkAll("R6 audio", expect_of(P_AUD, 0, 0, 0));
    detachWait();

    // R7 both Rd
    ptype = P_DBG;
    repeat (300) @(negedge clk);
    chk("R7 no attach", {attached, audioFlag, vbusEn, vconnEn}, 0);
    snkPhaseStart();
    chk("R7 still toggling", rdEn, 2'b11);
    detachWait();

    // R8 sink attach, R11 vbus loss
    ptype = P_SRC; pflip = 1;
    settle();
    chkAll("R8 sink attach", expect_of(P_SRC, 1, 0, 0));
    ptype = P_NONE;
    repeat (4) @(negedge clk);
    chk("R11 sink detach", attached, 0);
    repeat (40) @(negedge clk);

    // R9 dual-role partner, bias off then on
    snkPhaseStart();
    ptype = P_DRP; pflip = 0;
    settle();
    chkAll("R9 no bias -> sink", expect_of(P_DRP, 0, 0, 0));
    detachWait();
    trySrc = 1;
    snkPhaseStart();
    ptype = P_DRP; pflip = 1;
    settle();
    chkAll("R9 bias -> source", expect_of(P_DRP, 1, 0, 1));
    detachWait();
    trySrc = 0;

    // R12 power loss and dead-battery sink
    srcPhaseStart();
    pwr = 0;
    @(negedge clk);
    chk("R12 rp off", {rpEn, rdEn}, 4'b0011);
    ptype = P_SRC; pflip = 0;
    settle();
    chkAll("R12 unpowered sink", expect_of(P_SRC, 0, 0, 0));
    pwr = 1;
    repeat (10) @(negedge clk);
    chkAll("R12 power back stays sink", expect_of(P_SRC, 0, 0, 0));
    detachWait();

    // random episodes
    for (int k = 0; k < 30; k++) begin
      int t;
      trySrc = $urandom_range(0, 1);
      t = $urandom_range(1, 4);
      if (t == P_DRP && !trySrc) t = P_SNK;
      pflip = $urandom_range(0, 1);
      pcable = $urandom_range(0, 1);
      repeat ($urandom_range(0, 79)) @(negedge clk);
      ptype = t;
      settle();
      e = expect_of(t, pflip, pcable, trySrc);
      case (t)
        P_SNK: chkAll("R4 R5 random src", e);
        P_SRC: chkAll("R8 R9 random sink", e);
        P_DRP: chkAll("R9 random drp", e);
        default: chkAll("R6 random audio", e);
      endcase
      detachWait();
      chk("R10 R11 random detach", {attached, vbusEn, vconnEn, audioFlag}, 0);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule